// File: doc/BRIEF.md
# Hashed Inverted Page Table Walker

This block turns a virtual page number into a physical frame number. The lookup table is held on chip and has one slot for every index value. There are twice as many slots as physical frames. Each slot holds a valid flag, the full page number as its tag, the frame number it maps to, and a link to another slot. A lookup first folds the page number into a slot index and probes that slot. When the tag does not match, the walker follows the slot's link and probes again. The walk ends on a matching tag, which is a hit. It also ends on an empty slot, on a null link, or when the probe limit is reached, and these three cases are a page fault.

A requester hands over a page number with a valid/ready handshake. The walker takes a new request only while it is idle. It spends one clock per probe. It then presents the result: a hit flag, the frame number and the number of probes used. The result is held until the consumer takes it. The probe count lets the average walk length of a loaded table be measured. A plain write port loads or overwrites single slots.

Top module: `ipt_walker`

## Requirements
- R1: The first slot probed is the low IDX_W bits (IDX_W = FRAME_W+1) of the XOR of the page number's lower half and upper half. The lower half is bits HALF-1:0, the upper half is the bits above, and HALF = (VPN_W+1)/2. A page whose tag sits in that first slot gives a hit with probe count 1.
- R2: A probed slot that is valid and whose tag equals the requested page number ends the walk as a hit. The response carries that slot's stored frame number and the number of slots probed.
- R3: A valid slot whose tag does not match, and whose link is not null, sends the next probe to the slot index held in its link field.
- R4: A link field of all ones is null. A mismatch on a slot with a null link ends the walk as a fault. On every fault the frame output is zero.
- R5: A probed slot whose valid flag is clear ends the walk at once as a fault. This probe is counted.
- R6: When the walk reaches MAX_PROBES probes without a hit, it ends as a fault with probe count MAX_PROBES, even if the links form a loop.
- R7: Each probe takes exactly one clock. For a walk of N probes, rsp_valid rises N clocks after the clock that accepted the request.
- R8: req_ready is high only while the walker is idle. A request presented while a walk or a response is pending is ignored.
- R9: rsp_valid and the response fields hold steady until rsp_ready is seen high. On the clock that takes the response the walker returns to idle.
- R10: A write with wr_en high replaces the addressed slot's valid flag, tag, frame and link at the next clock. Later lookups see the new contents.
- R11: After reset every slot is invalid, req_ready is high and rsp_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Slot write strobe |
| wr_idx | input | IDX_W | Slot index to write |
| wr_valid | input | 1 | Valid flag to store |
| wr_tag | input | VPN_W | Page number tag to store |
| wr_frame | input | FRAME_W | Frame number to store |
| wr_link | input | IDX_W | Link index to store (all ones = null) |
| req_valid | input | 1 | Lookup request present |
| req_ready | output | 1 | Walker idle and able to take a request |
| req_vpn | input | VPN_W | Virtual page number to translate |
| rsp_valid | output | 1 | Result present |
| rsp_ready | input | 1 | Consumer takes the result |
| rsp_hit | output | 1 | 1 = hit, 0 = page fault |
| rsp_frame | output | FRAME_W | Frame number on a hit, zero on a fault |
| rsp_probes | output | CNT_W | Number of slots probed |

## Verification
Lookups run on a cold table, on a direct hit in the home slot, on a hit two links down a chain, and on a miss that runs off the end of that chain. Together they tell the hash, the tag compare and the link following apart. An empty home slot and a two-slot link loop separate the early fault on an invalid slot from the fault forced by the probe limit. Responses are held for several clocks while new requests are pushed at the busy walker, which shows both the hold and the refusal. A slot is then rewritten, and a page that faulted before must now hit with the new frame number.

// File: rtl/ipt_walker_pkg.sv
package ipt_walker_pkg;

   typedef enum logic [1:0] {
      WS_IDLE  = 2'd0,
      WS_PROBE = 2'd1,
      WS_RESP  = 2'd2
   } walk_state_e;

endpackage

// File: rtl/ipt_hash.sv
module ipt_hash #(
   parameter int VPN_W = 12,
   parameter int IDX_W = 5
) (
   input  logic [VPN_W-1:0] vpn,
   output logic [IDX_W-1:0] idx
);
   localparam int HALF = (VPN_W + 1) / 2;

   logic [HALF-1:0] lo_part;
   logic [HALF-1:0] hi_part;

   generate
      if (IDX_W > HALF) begin : g_bad_width
         $error("ipt_hash: index wider than half the page number");
      end
      if (VPN_W < 2) begin : g_bad_vpn
         $error("ipt_hash: page number too narrow to fold");
      end
   endgenerate

   always_comb begin
      lo_part = vpn[HALF-1:0];
      hi_part = HALF'(vpn >> HALF);
      idx     = IDX_W'(lo_part ^ hi_part);
   end

endmodule

// File: rtl/ipt_store.sv
module ipt_store #(
   parameter int VPN_W   = 12,
   parameter int FRAME_W = 4,
   parameter int IDX_W   = 5
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [IDX_W-1:0]   wr_idx,
   input  logic               wr_valid,
   input  logic [VPN_W-1:0]   wr_tag,
   input  logic [FRAME_W-1:0] wr_frame,
   input  logic [IDX_W-1:0]   wr_link,
   input  logic [IDX_W-1:0]   rd_idx,
   output logic               rd_valid,
   output logic [VPN_W-1:0]   rd_tag,
   output logic [FRAME_W-1:0] rd_frame,
   output logic [IDX_W-1:0]   rd_link
);
   localparam int SLOTS = 1 << IDX_W;

   logic               valid_q [SLOTS];
   logic [VPN_W-1:0]   tag_q   [SLOTS];
   logic [FRAME_W-1:0] frame_q [SLOTS];
   logic [IDX_W-1:0]   link_q  [SLOTS];

   generate
      for (genvar s = 0; s < SLOTS; s++) begin : g_slot
         logic sel;
         assign sel = wr_en && (wr_idx == IDX_W'(s));

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               valid_q[s] <= 1'b0;
            end else if (sel) begin
               valid_q[s] <= wr_valid;
            end
         end

         always_ff @(posedge clk) begin
            if (sel) begin
               tag_q[s]   <= wr_tag;
               frame_q[s] <= wr_frame;
               link_q[s]  <= wr_link;
            end
         end
      end
   endgenerate

   always_comb begin
      rd_valid = valid_q[rd_idx];
      rd_tag   = tag_q[rd_idx];
      rd_frame = frame_q[rd_idx];
      rd_link  = link_q[rd_idx];
   end

endmodule

// File: rtl/ipt_walker.sv
module ipt_walker
   import ipt_walker_pkg::*;
#(
   parameter int VPN_W      = 12,
   parameter int FRAME_W    = 4,
   parameter int MAX_PROBES = 8,
   localparam int IDX_W     = FRAME_W + 1,
   localparam int CNT_W     = $clog2(MAX_PROBES + 1)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [IDX_W-1:0]   wr_idx,
   input  logic               wr_valid,
   input  logic [VPN_W-1:0]   wr_tag,
   input  logic [FRAME_W-1:0] wr_frame,
   input  logic [IDX_W-1:0]   wr_link,
   input  logic               req_valid,
   output logic               req_ready,
   input  logic [VPN_W-1:0]   req_vpn,
   output logic               rsp_valid,
   input  logic               rsp_ready,
   output logic               rsp_hit,
   output logic [FRAME_W-1:0] rsp_frame,
   output logic [CNT_W-1:0]   rsp_probes
);
   localparam logic [IDX_W-1:0] NULL_LINK = '1;
   localparam logic [CNT_W-1:0] LIMIT     = CNT_W'(MAX_PROBES);

   generate
      if (MAX_PROBES < 1) begin : g_bad_limit
         $error("ipt_walker: MAX_PROBES must be at least 1");
      end
      if (FRAME_W < 1) begin : g_bad_frame
         $error("ipt_walker: FRAME_W must be at least 1");
      end
   endgenerate

   walk_state_e        state_q;
   logic [VPN_W-1:0]   vpn_q;
   logic [IDX_W-1:0]   cur_idx_q;
   logic [CNT_W-1:0]   probes_q;
   logic               hit_q;
   logic [FRAME_W-1:0] frame_q;
   logic [CNT_W-1:0]   used_q;

   logic [IDX_W-1:0]   home_idx;
   logic               slot_valid;
   logic [VPN_W-1:0]   slot_tag;
   logic [FRAME_W-1:0] slot_frame;
   logic [IDX_W-1:0]   slot_link;

   logic [CNT_W-1:0]   step;
   logic               match;
   logic               give_up;

   ipt_hash #(.VPN_W(VPN_W), .IDX_W(IDX_W)) u_hash (
      .vpn (req_vpn),
      .idx (home_idx)
   );

   ipt_store #(.VPN_W(VPN_W), .FRAME_W(FRAME_W), .IDX_W(IDX_W)) u_store (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .wr_idx   (wr_idx),
      .wr_valid (wr_valid),
      .wr_tag   (wr_tag),
      .wr_frame (wr_frame),
      .wr_link  (wr_link),
      .rd_idx   (cur_idx_q),
      .rd_valid (slot_valid),
      .rd_tag   (slot_tag),
      .rd_frame (slot_frame),
      .rd_link  (slot_link)
   );

   // Decision for the slot probed in this cycle
   always_comb begin
      step    = probes_q + 1'b1;
      match   = slot_valid && (slot_tag == vpn_q);
      give_up = !slot_valid || (slot_link == NULL_LINK) || (step == LIMIT);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= WS_IDLE;
         vpn_q     <= '0;
         cur_idx_q <= '0;
         probes_q  <= '0;
         hit_q     <= 1'b0;
         frame_q   <= '0;
         used_q    <= '0;
      end else begin
         unique case (state_q)
            WS_IDLE: begin
               if (req_valid) begin
                  vpn_q     <= req_vpn;
                  cur_idx_q <= home_idx;
                  probes_q  <= '0;
                  state_q   <= WS_PROBE;
               end
            end
            WS_PROBE: begin
               if (match) begin
                  hit_q   <= 1'b1;
                  frame_q <= slot_frame;
                  used_q  <= step;
                  state_q <= WS_RESP;
               end else if (give_up) begin
                  hit_q   <= 1'b0;
                  frame_q <= '0;
                  used_q  <= step;
                  state_q <= WS_RESP;
               end else begin
                  cur_idx_q <= slot_link;
                  probes_q  <= step;
               end
            end
            WS_RESP: begin
               if (rsp_ready) state_q <= WS_IDLE;
            end
            default: state_q <= WS_IDLE;
         endcase
      end
   end

   assign req_ready  = (state_q == WS_IDLE);
   assign rsp_valid  = (state_q == WS_RESP);
   assign rsp_hit    = hit_q;
   assign rsp_frame  = frame_q;
   assign rsp_probes = used_q;

   // R8
   accept_leaves_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && req_ready |=> !req_ready && !rsp_valid);

   // R9
   rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_hit)
                                  && $stable(rsp_frame) && $stable(rsp_probes));

   // R9
   rsp_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid && rsp_ready |=> !rsp_valid && req_ready);

   // R6
   probe_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> (rsp_probes != '0) && (rsp_probes <= LIMIT));

   // R4
   fault_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid && !rsp_hit |-> rsp_frame == '0);

   // R7
   walk_counter_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == WS_PROBE) && !match && !give_up |=> (state_q == WS_PROBE)
                                                    && (probes_q == $past(step)));

endmodule

// File: tb/ipt_walker_bench.sv
module ipt_walker_bench;
   localparam int VPN_W = 12;
   localparam int FRAME_W = 4;
   localparam int MAXP = 8;
   localparam int IDX_W = FRAME_W + 1;
   localparam int CNT_W = $clog2(MAXP + 1);
   localparam int SLOTS = 1 << IDX_W;
   localparam int NUL = SLOTS - 1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic wr_en = 1'b0;
   logic [IDX_W-1:0] wr_idx = '0;
   logic wr_valid = 1'b0;
   logic [VPN_W-1:0] wr_tag = '0;
   logic [FRAME_W-1:0] wr_frame = '0;
   logic [IDX_W-1:0] wr_link = '0;
   logic req_valid = 1'b0;
   logic req_ready;
   logic [VPN_W-1:0] req_vpn = '0;
   logic rsp_valid;
   logic rsp_ready = 1'b0;
   logic rsp_hit;
   logic [FRAME_W-1:0] rsp_frame;
   logic [CNT_W-1:0] rsp_probes;

   always #10 clk = ~clk;

   ipt_walker #(.VPN_W(VPN_W), .FRAME_W(FRAME_W), .MAX_PROBES(MAXP)) u_ipt_walker (
      .clk(clk), .rst_n(rst_n),
      .wr_en(wr_en), .wr_idx(wr_idx), .wr_valid(wr_valid), .wr_tag(wr_tag),
      .wr_frame(wr_frame), .wr_link(wr_link),
      .req_valid(req_valid), .req_ready(req_ready), .req_vpn(req_vpn),
      .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_hit(rsp_hit),
      .rsp_frame(rsp_frame), .rsp_probes(rsp_probes)
   );

   int n_chk = 0;
   int n_err = 0;
   bit done = 1'b0;
   string cur_rq = "R11";

   // Behavioural table and model state
   int b_valid [SLOTS];
   int b_tag   [SLOTS];
   int b_frame [SLOTS];
   int b_link  [SLOTS];
   int m_st = 0;
   int m_cnt = 0;
   int e_hit = 0, e_frame = 0, e_probes = 0;
   int sum_probes = 0, n_lookups = 0;

   task automatic chk(string rq, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_err++;
         $display("FAIL %s: got %0d expected %0d", rq, act, exp);
      end
   endtask

   function automatic int bhash(int v);
      return (v ^ (v >> 6)) & (SLOTS - 1);
   endfunction

   task automatic walk(input int v, output int h, output int f, output int p);
      int idx;
      idx = bhash(v);
      h = 0; f = 0; p = 0;
      forever begin
         p++;
         if (b_valid[idx] == 0) return;
         if (b_tag[idx] == v) begin h = 1; f = b_frame[idx]; return; end
         if (b_link[idx] == NUL || p == MAXP) return;
         idx = b_link[idx];
      end
   endtask

   always @(posedge clk) begin
      if (!rst_n) begin
         m_st = 0;
      end else begin
         case (m_st)
            0: if (req_valid) begin
               walk(int'(req_vpn), e_hit, e_frame, e_probes);
               m_cnt = e_probes;
               m_st = 1;
               sum_probes += e_probes;
               n_lookups++;
            end
            1: begin
               m_cnt--;
               if (m_cnt == 0) m_st = 2;
            end
            default: if (rsp_ready) m_st = 0;
         endcase
      end
   end

   // Compare against the model on every clock, away from the active edge
   always @(negedge clk) begin
      if (rst_n && !done) begin
         chk({cur_rq, " R8 req_ready"}, int'(req_ready), int'(m_st == 0));
         chk({cur_rq, " R7 rsp_valid"}, int'(rsp_valid), int'(m_st == 2));
         if (m_st == 2) begin
            chk({cur_rq, " R9 hit"}, int'(rsp_hit), e_hit);
            chk({cur_rq, " R9 frame"}, int'(rsp_frame), e_frame);
            chk({cur_rq, " R9 probes"}, int'(rsp_probes), e_probes);
         end
      end
   end

   task automatic put(int idx, int v, int tag, int frame, int link);
      @(negedge clk);
      wr_en = 1'b1; wr_idx = IDX_W'(idx); wr_valid = v[0];
      wr_tag = VPN_W'(tag); wr_frame = FRAME_W'(frame); wr_link = IDX_W'(link);
      b_valid[idx] = v; b_tag[idx] = tag; b_frame[idx] = frame; b_link[idx] = link;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   // Issue one lookup; hold the response for 'hold' cycles; optionally
   // keep pushing another request at the busy walker
   task automatic lookup(string rq, int v, int hold, bit noise, int exp_hit, int exp_p);
      cur_rq = rq;
      @(negedge clk);
      req_valid = 1'b1; req_vpn = VPN_W'(v);
      @(negedge clk);
      if (noise) req_vpn = VPN_W'(v ^ 12'h0A5);
      else req_valid = 1'b0;
      while (!rsp_valid) @(negedge clk);
      chk({rq, " result hit"}, int'(rsp_hit), exp_hit);
      chk({rq, " result probes"}, int'(rsp_probes), exp_p);
      repeat (hold) @(negedge clk);
      rsp_ready = 1'b1; req_valid = 1'b0;
      @(negedge clk);
      rsp_ready = 1'b0;
      chk({rq, " R9 back to idle"}, int'(req_ready), 1);
   endtask

   initial begin
      for (int i = 0; i < SLOTS; i++) begin
         b_valid[i] = 0; b_tag[i] = 0; b_frame[i] = 0; b_link[i] = NUL;
      end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R11 reset req_ready", int'(req_ready), 1);
      chk("R11 reset rsp_valid", int'(rsp_valid), 0);

      // R11: empty table faults on the first probe
      lookup("R11", 12'h005, 0, 1'b0, 0, 1);

      // Home slot of 0x005 is 5; 0x044 also folds to 5
      put(5, 1, 12'h005, 3, 20);
      put(20, 1, 12'h044, 9, NUL);
      put(12, 1, 12'h00C, 15, NUL);
      put(8, 1, 12'h100, 1, 9);
      put(9, 1, 12'h101, 2, 8);

      lookup("R1", 12'h005, 0, 1'b0, 1, 1);
      lookup("R2", 12'h005, 3, 1'b0, 1, 1);
      lookup("R3", 12'h044, 0, 1'b0, 1, 2);
      lookup("R4", 12'h087, 0, 1'b0, 0, 2);
      lookup("R4", 12'h04D, 0, 1'b0, 0, 1);
      lookup("R5", 12'h100, 0, 1'b0, 0, 1);
      lookup("R6", 12'h008, 0, 1'b0, 0, MAXP);
      lookup("R7", 12'h044, 1, 1'b0, 1, 2);
      lookup("R8", 12'h044, 4, 1'b1, 1, 2);
      lookup("R9", 12'h008, 6, 1'b1, 0, MAXP);

      // R10: rewrite slot 20, a page that faulted before now hits
      lookup("R10", 12'h101, 0, 1'b0, 0, 2);
      put(20, 1, 12'h101, 11, NUL);
      lookup("R10", 12'h101, 0, 1'b0, 1, 2);
      chk("R10 frame after rewrite", int'(rsp_frame), 11);
      put(5, 0, 12'h005, 3, 20);
      lookup("R10", 12'h005, 0, 1'b0, 0, 1);

      repeat (2) @(negedge clk);
      done = 1'b1;
      $display("average probes x100: %0d", (sum_probes * 100) / n_lookups);
      $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_chk++;
         n_err++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
         $finish;
      end
   end

endmodule